// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog. It has a two-stage timebase. The first stage is an 8-bit prescaler that divides the input clock by P+1. The second stage is a post-divider that divides by 16, 32, 64 or 128. Each timebase tick moves a 16-bit down-counter one step toward zero. When the counter is at zero and a tick arrives, the counter expires. On expiry the block can latch a level interrupt, emit a one-clock system reset request, or do both, under two independent enables.

Software keeps the system alive by writing the live count register before expiry. A separate reload register holds the value the counter takes after each expiry. A write-only clear location drops the pending interrupt. Writing zero to the control word stops the timer completely.

Top module: `wdt_prescaled`

## Requirements
- R1: Byte offsets select the registers: 0x0 is control, 0x4 is reload, 0x8 is live count, and 0xC is interrupt clear. After reset, control reads 0, reload reads 0x8000 and count reads 0x8000. The irq and sys_rst_req outputs are low.
- R2: Control layout: bit 0 enables the reset request, bit 2 enables the interrupt, bits [4:3] select the post-divider and bit 5 enables the timer. Bits [15:8] hold the prescale value P. Control reads back only these fields, so writing all ones reads 0x0000FF3D.
- R3: While the timer is enabled, one tick occurs every (P+1)·2^(4+sel) clocks, where sel = 0..3. Each tick lowers a non-zero count by one.
- R4: A tick that finds the count at zero is an expiry, and the count becomes the reload value. Suppose a count C is loaded while the timer is stopped, and the timer is then enabled at clock edge E. The first expiry then lands on edge E + (P+1)·2^(4+sel)·(C+1).
- R5: On expiry with the interrupt enable set, irq rises. It stays high until a clear write, even across later ticks.
- R6: A write of any value to offset 0xC lowers irq. A read of offset 0xC returns zero.
- R7: On expiry with the reset enable set, sys_rst_req is high for exactly one clock. With the reset enable clear, it never rises.
- R8: With the timer enable clear, the count holds its value and the timebase is held at zero. After re-enabling, the first tick therefore arrives only after a full tick period.
- R9: A write to offset 0x8 loads the count at any time. Writing the count repeatedly before it expires prevents any expiry.
- R10: If a count write lands on the same edge as an expiry, the written value is loaded instead of the reload value. The expiry still raises irq when the interrupt enable is set.
- R11: With the interrupt enable clear, an expiry leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also feeds the timebase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level interrupt; pending since an expiry |
| sys_rst_req | output | 1 | One-clock system reset request on expiry |

## Verification
The keepalive write and the automatic reload both target the live count on the same edge when an expiry is due. The bench enables the timer with the count at zero and the fastest timebase. It counts clocks so that a count write is placed exactly on the sixteenth edge after the enabling edge, where the expiry tick falls. It then checks two things: the count reads the written value rather than the reload value, and irq has still risen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Word index of each register (byte offset >> 2)
  typedef enum logic [1:0] {
    W_CTRL   = 2'd0,
    W_RELOAD = 2'd1,
    W_COUNT  = 2'd2,
    W_CLEAR  = 2'd3
  } wdt_word_e;

  // Control field positions
  localparam int CB_RST_EN  = 0;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_DSEL_LO = 3;
  localparam int CB_RUN     = 5;
  localparam int CB_PRE_LO  = 8;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 4,
  parameter int          CNT_W   = 16,
  parameter int          PRE_W   = 8,
  parameter int          DSEL_W  = 2,
  parameter logic [15:0] CNT_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              run,
  output logic [PRE_W-1:0]  pre,
  output logic [DSEL_W-1:0] dsel,
  output logic              irq_en,
  output logic              rst_en,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic              clr_wr
);
  logic              hit;
  wdt_word_e         word;
  logic              ctrl_wr, rel_wr;

  logic              run_q, run_d, irqen_q, irqen_d, rsten_q, rsten_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DSEL_W-1:0] dsel_q, dsel_d;
  logic [CNT_W-1:0]  rel_q, rel_d;

  // Address decode: upper address bits above the four words must be zero
  generate
    if (ADDR_W > 4) begin : g_wide
      assign hit = (addr[ADDR_W-1:4] == '0);
    end else begin : g_exact
      assign hit = 1'b1;
    end
  endgenerate

  assign word    = wdt_word_e'(addr[3:2]);
  assign ctrl_wr = wr_en && hit && (word == W_CTRL);
  assign rel_wr  = wr_en && hit && (word == W_RELOAD);
  assign cnt_wr  = wr_en && hit && (word == W_COUNT);
  assign clr_wr  = wr_en && hit && (word == W_CLEAR);

  always_comb begin
    run_d   = run_q;
    irqen_d = irqen_q;
    rsten_d = rsten_q;
    pre_d   = pre_q;
    dsel_d  = dsel_q;
    rel_d   = rel_q;
    if (ctrl_wr) begin
      run_d   = wdata[CB_RUN];
      irqen_d = wdata[CB_IRQ_EN];
      rsten_d = wdata[CB_RST_EN];
      pre_d   = wdata[CB_PRE_LO +: PRE_W];
      dsel_d  = wdata[CB_DSEL_LO +: DSEL_W];
    end
    if (rel_wr) rel_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q   <= 1'b0;
      irqen_q <= 1'b0;
      rsten_q <= 1'b0;
      pre_q   <= '0;
      dsel_q  <= '0;
      rel_q   <= CNT_W'(CNT_RST);
    end else begin
      run_q   <= run_d;
      irqen_q <= irqen_d;
      rsten_q <= rsten_d;
      pre_q   <= pre_d;
      dsel_q  <= dsel_d;
      rel_q   <= rel_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (word)
        W_CTRL: begin
          rdata[CB_RUN]                 = run_q;
          rdata[CB_IRQ_EN]              = irqen_q;
          rdata[CB_RST_EN]              = rsten_q;
          rdata[CB_PRE_LO +: PRE_W]     = pre_q;
          rdata[CB_DSEL_LO +: DSEL_W]   = dsel_q;
        end
        W_RELOAD: rdata[CNT_W-1:0] = rel_q;
        W_COUNT:  rdata[CNT_W-1:0] = cnt_val;
        default:  rdata = '0;
      endcase
    end
  end

  wire unused_bus = ^{addr[1:0], wdata[DATA_W-1:CB_PRE_LO+PRE_W],
                      wdata[CB_PRE_LO-1:CB_RUN+1], wdata[1]};

  assign run    = run_q;
  assign pre    = pre_q;
  assign dsel   = dsel_q;
  assign irq_en = irqen_q;
  assign rst_en = rsten_q;
  assign reload = rel_q;
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int PRE_W        = 8,
  parameter int DSEL_W       = 2,
  parameter int DIV_LOG_BASE = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);
  localparam int SEL_MAX = (1 << DSEL_W) - 1;
  localparam int DIV_W   = DIV_LOG_BASE + SEL_MAX;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DIV_W-1:0]  div_last;
  logic [DSEL_W-1:0] shamt;
  logic              pre_wrap, div_wrap;

  // Terminal value 2^(BASE+sel)-1 from an all-ones word shifted right
  assign shamt    = DSEL_W'(SEL_MAX) - dsel;
  assign div_last = {DIV_W{1'b1}} >> shamt;
  assign pre_wrap = (pre_q >= pre);
  assign div_wrap = (div_q >= div_last);
  assign tick     = run && pre_wrap && div_wrap;

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    if (!run) begin
      pre_d = '0;
      div_d = '0;
    end else if (pre_wrap) begin
      pre_d = '0;
      div_d = div_wrap ? '0 : div_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] CNT_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             clr_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d, rst_q, rst_d;
  logic             expire;

  assign expire = tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)      cnt_d = cnt_wval;
    else if (expire) cnt_d = reload;
    else if (tick)   cnt_d = cnt_q - 1'b1;

    irq_d = irq_q;
    if (expire && irq_en) irq_d = 1'b1;
    else if (clr_wr)      irq_d = 1'b0;

    rst_d = expire && rst_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= CNT_W'(CNT_RST);
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign cnt     = cnt_q;
  assign irq     = irq_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 4,
  parameter int          CNT_W        = 16,
  parameter int          PRE_W        = 8,
  parameter int          DSEL_W       = 2,
  parameter int          DIV_LOG_BASE = 4,
  parameter logic [15:0] CNT_RST      = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sys_rst_req
);
  logic              srst_n;
  logic              run, irq_en, rst_en, cnt_wr, clr_wr, tick;
  logic [PRE_W-1:0]  pre;
  logic [DSEL_W-1:0] dsel;
  logic [CNT_W-1:0]  reload_val, cnt_val;

  wdt_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  wdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .PRE_W(PRE_W), .DSEL_W(DSEL_W), .CNT_RST(CNT_RST)
  ) u_regs (
    .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_val(cnt_val),
    .run(run), .pre(pre), .dsel(dsel), .irq_en(irq_en),
    .rst_en(rst_en), .reload(reload_val), .cnt_wr(cnt_wr),
    .clr_wr(clr_wr)
  );

  wdt_timebase #(
    .PRE_W(PRE_W), .DSEL_W(DSEL_W), .DIV_LOG_BASE(DIV_LOG_BASE)
  ) u_tb (
    .clk(clk), .srst_n(srst_n), .run(run), .pre(pre),
    .dsel(dsel), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
    .clk(clk), .srst_n(srst_n), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wval(wdata[CNT_W-1:0]), .reload(reload_val),
    .irq_en(irq_en), .rst_en(rst_en), .clr_wr(clr_wr),
    .cnt(cnt_val), .irq(irq), .rst_req(sys_rst_req)
  );
endmodule

// File: rtl/wdt_prescaled_chk.sv
module wdt_prescaled_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              sys_rst_req,
  input logic              run,
  input logic              rst_en,
  input logic              tick,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload
);
  logic clr_hit;
  assign clr_hit = (addr == ADDR_W'(12));

  p_decrement_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && cnt != '0 && !cnt_wr) |=> cnt == $past(cnt) - CNT_W'(1));

  p_reload_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && cnt == '0 && !cnt_wr) |=> cnt == $past(reload));

  p_irq_holds_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !(wr_en && clr_hit)) |=> irq);

  p_clear_reads_zero_r6: assert property (@(posedge clk) disable iff (!srst_n)
    clr_hit |-> rdata == '0);

  p_rst_one_cycle_r7: assert property (@(posedge clk) disable iff (!srst_n)
    sys_rst_req |=> !sys_rst_req);

  p_rst_needs_enable_r7: assert property (@(posedge clk) disable iff (!srst_n)
    sys_rst_req |-> $past(rst_en));

  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_wr |=> cnt == $past(wdata[CNT_W-1:0]));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req),
  .run(run), .rst_en(rst_en), .tick(tick), .cnt_wr(cnt_wr),
  .cnt(cnt_val), .reload(reload_val)
);

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
  localparam int T_HALF = 4;  // 125 MHz

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wdt_prescaled u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #T_HALF clk = ~clk;

  // Vector: {pre[7:0], sel[7:0], start[15:0], reload[15:0]}
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {8'd0,   8'd0, 16'd2, 16'h0030},
    {8'd3,   8'd1, 16'd1, 16'h1234},
    {8'd1,   8'd3, 16'd0, 16'hBEEF},
    {8'd255, 8'd0, 16'd0, 16'h0001},
    {8'd0,   8'd2, 16'd5, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [7:0] p, input logic [1:0] s,
                                            input bit run, input bit ie, input bit re);
    return {16'h0, p, 2'b00, run, s, ie, 1'b0, re};
  endfunction

  initial begin
    #(2 * T_HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'h0, d); chk(d == 32'h0, "R1 ctrl reset", d, 32'h0);
    rd(4'h4, d); chk(d == 32'h8000, "R1 reload reset", d, 32'h8000);
    rd(4'h8, d); chk(d == 32'h8000, "R1 count reset", d, 32'h8000);
    chk(irq == 1'b0 && sys_rst_req == 1'b0, "R1 outputs low", {irq, sys_rst_req}, 0);

    // R2 control readback mask
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h0, 32'h0);
    wr(4'h0, 32'hFFFF_FFDF);  // all fields but run
    rd(4'h0, d); chk(d == 32'h0000_FF1D, "R2 ctrl readback", d, 32'h0000_FF1D);
    wr(4'h0, 32'h0);

    // R3 R4 R5 table of timebase settings
    for (int v = 0; v < NV; v++) begin
      logic [7:0] p; logic [1:0] s; logic [15:0] c0, rl;
      int expn;
      p = VEC[v][47:40]; s = VEC[v][33:32]; c0 = VEC[v][31:16]; rl = VEC[v][15:0];
      expn = (int'(p) + 1) * (16 << s) * (int'(c0) + 1);
      wr(4'h0, 32'h0); wr(4'hC, 32'h0); wr(4'h8, {16'h0, c0}); wr(4'h4, {16'h0, rl});
      wr(4'h0, ctrl_word(p, s, 1, 1, 0));
      n = 0;
      while (!irq && n < 20000) begin @(negedge clk); n++; end
      chk(n == expn, "R3 R4 expiry time", n, expn);
      rd(4'h8, d); chk(d == {16'h0, rl}, "R4 reload after expiry", d, {16'h0, rl});
      repeat (40) @(negedge clk);
      chk(irq == 1'b1, "R5 irq stays pending", irq, 1);
    end

    // R6 clear with arbitrary data, read of clear location
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h5A5A_1234);
    chk(irq == 1'b0, "R6 clear lowers irq", irq, 0);
    rd(4'hC, d); chk(d == 32'h0, "R6 clear reads zero", d, 0);

    // R7 R11 reset request pulse, interrupt disabled
    wr(4'h8, 32'h0);
    wr(4'h0, ctrl_word(8'd0, 2'd0, 1, 0, 1));
    n = 0;
    while (!sys_rst_req && n < 2000) begin @(negedge clk); n++; end
    chk(n == 16, "R7 reset request time", n, 16);
    @(negedge clk);
    chk(sys_rst_req == 1'b0, "R7 reset pulse one clock", sys_rst_req, 0);
    chk(irq == 1'b0, "R11 no irq when disabled", irq, 0);

    // R7 R8 full disable: no reset request, count holds
    wr(4'h0, 32'h0); wr(4'h8, 32'h0);
    n = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (sys_rst_req) n++; end
    chk(n == 0, "R7 no request when off", n, 0);
    rd(4'h8, d); chk(d == 32'h0, "R8 count holds when off", d, 0);

    // R8 re-enable gives a full period
    wr(4'h8, 32'h1);
    wr(4'h0, ctrl_word(8'd0, 2'd0, 1, 1, 0));
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h0); wr(4'h8, 32'h1); wr(4'hC, 32'h0);
    wr(4'h0, ctrl_word(8'd0, 2'd0, 1, 1, 0));
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk(n == 32, "R8 full period after re-enable", n, 32);

    // R9 keepalive
    wr(4'h0, 32'h0); wr(4'hC, 32'h0); wr(4'h8, 32'h3);
    wr(4'h0, ctrl_word(8'd0, 2'd0, 1, 1, 0));
    n = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (38) begin @(negedge clk); if (irq) n++; end
      wr(4'h8, 32'h3);
    end
    chk(n == 0, "R9 keepalive prevents expiry", n, 0);
    rd(4'h8, d); chk(d <= 32'h3, "R9 count reloaded by write", d, 3);

    // R10 count write on the expiry edge
    wr(4'h0, 32'h0); wr(4'hC, 32'h0); wr(4'h8, 32'h0); wr(4'h4, 32'h50);
    wr(4'h0, ctrl_word(8'd0, 2'd0, 1, 1, 0));
    repeat (15) @(negedge clk);
    wr_en = 1'b1; addr = 4'h8; wdata = 32'h0777;
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'h8, d); chk(d == 32'h0777, "R10 write wins over reload", d, 32'h0777);
    chk(irq == 1'b1, "R10 expiry still flags irq", irq, 1);
    wr(4'h0, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule